// File: doc/BRIEF.md
# Sync Polarity and Frequency Evaluator

This block measures the horizontal and vertical sync inputs of a display front end so that firmware can identify the video mode. Each sync input first passes through a digital glitch filter. A polarity detector then decides, for each filtered signal, whether its pulses are high-going or low-going. The block reports two timings. The vertical timing is the time between successive vertical sync pulses, counted in 8 µs ticks. The horizontal timing is the number of horizontal sync pulses seen inside a fixed gate window. The gate window is 1024 ticks of 8 µs, or 8.192 ms, at default parameters.

Each measurement has its own counter. A counter saturates at all-ones and sets a sticky overflow flag, which software clears with a dedicated one-cycle strobe. Every vertical sync event latches a new vertical result and raises a one-cycle interrupt pulse. When composite mode is selected, the vertical event is taken from the horizontal input instead. It is the moment the horizontal input has stayed at its pulse level for a programmable number of clock cycles.

Top module: `sync_eval`

## Requirements
- R1: While `rst_ni` is low, `vcnt_o` and `hcnt_o` read 0, `vovf_o`, `hovf_o` and `vint_o` read 0, and both polarity outputs read 0.
- R2: The vertical result is the number of 8 µs ticks (a tick every `CLK_PER_US*VTICK_US` clocks) between two successive leading edges of the vertical source. The leading edge is the transition into the pulse level. The result is latched at each leading edge, the tick occurring in that same cycle is included, and the counter then restarts from zero.
- R3: `vint_o` is high for exactly one cycle, and that is the cycle in which `vcnt_o` first shows a newly latched value.
- R4: `hcnt_o` holds the number of horizontal leading edges seen within the last complete gate window of `HWIN_TICKS` 8 µs ticks. It is updated once at the end of each window.
- R5: Each counter saturates at all-ones (2^CNT_W−1) and then sets its overflow flag. The flag stays at 1 until its clear strobe (`clr_vovf_i` or `clr_hovf_i`) is high for a cycle with no new overflow.
- R6: A polarity output is 1 (positive) when the high time of a period is shorter than its low time, and 0 otherwise. The output changes only when two consecutive periods give the same verdict, so a single odd period is ignored.
- R7: A level change on a sync input that lasts fewer than `FILT_LEN` clock cycles has no effect on any count, flag or polarity.
- R8: With `comp_mode_i` = 1, the vertical source is the horizontal input held at its pulse level for at least `EXT_CYC` consecutive clocks. The vertical result is then the frame period in 8 µs ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (8 MHz nominal) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Horizontal (or composite) sync, synchronous |
| vsync_i | input | 1 | Vertical sync, synchronous |
| comp_mode_i | input | 1 | 1: take vertical timing from the horizontal input |
| clr_hovf_i | input | 1 | Clear strobe for the horizontal overflow flag |
| clr_vovf_i | input | 1 | Clear strobe for the vertical overflow flag |
| hpol_o | output | 1 | Horizontal polarity, 1 = positive |
| vpol_o | output | 1 | Vertical polarity, 1 = positive |
| vcnt_o | output | CNT_W | Latched vertical period in 8 µs ticks |
| hcnt_o | output | CNT_W | Latched horizontal pulse count per window |
| hovf_o | output | 1 | Sticky horizontal overflow |
| vovf_o | output | 1 | Sticky vertical overflow |
| vint_o | output | 1 | One-cycle pulse on each vertical event |

## Verification
The bench uses periods that are whole multiples of the tick, and horizontal periods that divide the gate window evenly, so every latched count has one exact expected value. A counter that dropped the tick in the latch cycle, or that missed the restart, would read one short or carry a value over from the previous period. Inverting each input checks that the measurement follows the leading edge into the pulse level and that the polarity verdict flips. One-cycle glitches and the single long period of a composite frame check that the filter and the two-period agreement rule hold the counts and polarity steady. Overflow runs check saturation at all-ones and a flag that survives normal traffic until its strobe.

// File: rtl/sync_eval_pkg.sv
package sync_eval_pkg;
  typedef enum logic {POL_NEG = 1'b0, POL_POS = 1'b1} sync_pol_e;
  localparam int CH_V = 0;
  localparam int CH_H = 1;
  localparam int N_CH = 2;
endpackage

// File: rtl/sync_tick_gen.sv
module sync_tick_gen #(
  parameter int CLK_PER_US = 8,
  parameter int VTICK_US   = 8,
  parameter int HWIN_TICKS = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o,
  output logic win_end_o
);
  localparam int US_W  = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam int VT_W  = (VTICK_US > 1)   ? $clog2(VTICK_US)   : 1;
  localparam int WIN_W = (HWIN_TICKS > 1) ? $clog2(HWIN_TICKS) : 1;

  logic [US_W-1:0]  us_q;
  logic [VT_W-1:0]  vt_q;
  logic [WIN_W-1:0] win_q;
  logic us_last, vt_last, win_last;

  assign us_last   = (us_q == US_W'(CLK_PER_US - 1));
  assign vt_last   = (vt_q == VT_W'(VTICK_US - 1));
  assign win_last  = (win_q == WIN_W'(HWIN_TICKS - 1));
  assign tick_o    = us_last && vt_last;
  assign win_end_o = tick_o && win_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      us_q  <= '0;
      vt_q  <= '0;
      win_q <= '0;
    end else begin
      us_q <= us_last ? '0 : us_q + 1'b1;
      if (us_last) vt_q <= vt_last ? '0 : vt_q + 1'b1;
      if (tick_o) win_q <= win_last ? '0 : win_q + 1'b1;
    end
  end

  AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((CLK_PER_US * VTICK_US > 1) && tick_o) |=> !tick_o); // R2
endmodule

// File: rtl/sync_glitch_filter.sv
module sync_glitch_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic sig_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [CW-1:0] run_q;
  logic          out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      out_q <= 1'b0;
    end else if (sig_i != out_q) begin
      if (run_q == CW'(FILT_LEN - 1)) begin
        out_q <= sig_i;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end else begin
      run_q <= '0;
    end
  end

  assign sig_o = out_q;

  AST_FILT_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(out_q) |-> ($past(sig_i) == out_q)); // R7
endmodule

// File: rtl/sync_pol_detect.sv
module sync_pol_detect
  import sync_eval_pkg::*;
#(
  parameter int POL_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic pol_o
);
  logic [POL_W-1:0] run_q, hi_len_q;
  logic sig_q, seen_rise_q, hi_ok_q;
  sync_pol_e last_q, pol_q;
  sync_pol_e verdict;
  logic rise, fall;

  assign rise    = sig_i && !sig_q;
  assign fall    = !sig_i && sig_q;
  // short high phase => positive pulses
  assign verdict = (hi_len_q < run_q) ? POL_POS : POL_NEG;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sig_q       <= 1'b0;
      run_q       <= '0;
      hi_len_q    <= '0;
      seen_rise_q <= 1'b0;
      hi_ok_q     <= 1'b0;
      last_q      <= POL_NEG;
      pol_q       <= POL_NEG;
    end else begin
      sig_q <= sig_i;
      if (rise || fall) run_q <= POL_W'(1);
      else if (!(&run_q)) run_q <= run_q + 1'b1;
      if (fall && seen_rise_q) begin
        hi_len_q <= run_q;
        hi_ok_q  <= 1'b1;
      end
      if (rise) begin
        seen_rise_q <= 1'b1;
        if (hi_ok_q) begin
          last_q <= verdict;
          if (verdict == last_q) pol_q <= verdict;
        end
      end
    end
  end

  assign pol_o = pol_q;

  AST_POL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise |=> $stable(pol_q)); // R6
endmodule

// File: rtl/sync_evt_counter.sv
module sync_evt_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             latch_i,
  input  logic             clr_ovf_i,
  output logic [CNT_W-1:0] res_o,
  output logic             ovf_o,
  output logic             latched_o
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic at_max;

  assign at_max  = &cnt_q;
  assign cnt_nxt = (inc_i && !at_max) ? cnt_q + 1'b1 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      res_o     <= '0;
      ovf_o     <= 1'b0;
      latched_o <= 1'b0;
    end else begin
      latched_o <= latch_i;
      if (latch_i) begin
        res_o <= cnt_nxt;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_nxt;
      end
      if (inc_i && at_max) ovf_o <= 1'b1;
      else if (clr_ovf_i)  ovf_o <= 1'b0;
    end
  end

  AST_CNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_i |=> (cnt_q == '0)); // R2
  AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && at_max) |=> ovf_o); // R5
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !clr_ovf_i) |=> ovf_o); // R5
  AST_ONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latched_o |-> (res_o == $past(cnt_nxt))); // R3
endmodule

// File: rtl/sync_eval.sv
module sync_eval
  import sync_eval_pkg::*;
#(
  parameter int CLK_PER_US = 8,
  parameter int VTICK_US   = 8,
  parameter int HWIN_TICKS = 1024,
  parameter int CNT_W      = 12,
  parameter int FILT_LEN   = 3,
  parameter int EXT_CYC    = 160,
  parameter int POL_W      = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hsync_i,
  input  logic             vsync_i,
  input  logic             comp_mode_i,
  input  logic             clr_hovf_i,
  input  logic             clr_vovf_i,
  output logic             hpol_o,
  output logic             vpol_o,
  output logic [CNT_W-1:0] vcnt_o,
  output logic [CNT_W-1:0] hcnt_o,
  output logic             hovf_o,
  output logic             vovf_o,
  output logic             vint_o
);
  localparam int EXT_W = $clog2(EXT_CYC + 1);

  logic tick, win_end;
  logic [N_CH-1:0] raw, filt, pol;

  assign raw[CH_V] = vsync_i;
  assign raw[CH_H] = hsync_i;

  sync_tick_gen #(
    .CLK_PER_US(CLK_PER_US), .VTICK_US(VTICK_US), .HWIN_TICKS(HWIN_TICKS)
  ) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick), .win_end_o(win_end)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    sync_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(raw[c]), .sig_o(filt[c])
    );
    sync_pol_detect #(.POL_W(POL_W)) u_pol (
      .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(filt[c]), .pol_o(pol[c])
    );
  end

  assign vpol_o = pol[CH_V];
  assign hpol_o = pol[CH_H];

  // pulse-normalised levels: 1 while inside a sync pulse
  logic h_in_pulse, v_in_pulse;
  assign h_in_pulse = (filt[CH_H] == pol[CH_H]);
  assign v_in_pulse = (filt[CH_V] == pol[CH_V]);

  // composite extraction: long stay at the horizontal pulse level
  logic [EXT_W-1:0] ext_run_q;
  logic ext_v;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_run_q <= '0;
    else if (!h_in_pulse) ext_run_q <= '0;
    else if (ext_run_q != EXT_W'(EXT_CYC)) ext_run_q <= ext_run_q + 1'b1;
  end
  assign ext_v = (ext_run_q == EXT_W'(EXT_CYC));

  logic v_src, v_src_q, h_src_q, v_edge, h_edge;
  assign v_src = comp_mode_i ? ext_v : v_in_pulse;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_src_q <= 1'b0;
      h_src_q <= 1'b0;
    end else begin
      v_src_q <= v_src;
      h_src_q <= h_in_pulse;
    end
  end

  assign v_edge = v_src && !v_src_q;
  assign h_edge = h_in_pulse && !h_src_q;

  sync_evt_counter #(.CNT_W(CNT_W)) u_vcnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(tick), .latch_i(v_edge),
    .clr_ovf_i(clr_vovf_i), .res_o(vcnt_o), .ovf_o(vovf_o), .latched_o(vint_o)
  );

  logic h_latched;
  sync_evt_counter #(.CNT_W(CNT_W)) u_hcnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(h_edge), .latch_i(win_end),
    .clr_ovf_i(clr_hovf_i), .res_o(hcnt_o), .ovf_o(hovf_o), .latched_o(h_latched)
  );

  AST_EXT_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !h_in_pulse |=> !ext_v); // R8
  AST_HCNT_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !h_latched |-> $stable(hcnt_o)); // R4
  AST_VINT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vint_o |=> !vint_o); // R3
endmodule

// File: tb/sync_eval_test.sv
`timescale 1ns/100ps
module sync_eval_test;
  localparam int CW = 6;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic hsync_i = 1'b0, vsync_i = 1'b0, comp_mode_i = 1'b0;
  logic clr_hovf_i = 1'b0, clr_vovf_i = 1'b0;
  logic hpol_o, vpol_o, hovf_o, vovf_o, vint_o;
  logic [CW-1:0] vcnt_o, hcnt_o;

  always #2.5 clk_i = ~clk_i;

  // tick = 16 clocks, window = 256 clocks
  sync_eval #(
    .CLK_PER_US(2), .VTICK_US(8), .HWIN_TICKS(16), .CNT_W(CW),
    .FILT_LEN(2), .EXT_CYC(40), .POL_W(10)
  ) uut (.*);

  int n_tests = 0, n_fail = 0;

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  // stimulus controls
  int vper = 0, vhi = 0, hper = 0, hhi = 0;
  logic vinv = 1'b0, hinv = 1'b0, vglitch = 1'b0, cmode = 1'b0;

  initial begin : vgen
    @(posedge rst_ni);
    wait_cyc(1);
    forever begin
      if (vper == 0) wait_cyc(1);
      else begin
        int p, h, a;
        p = vper; h = vhi; a = (p - h) / 2;
        vsync_i = ~vinv; wait_cyc(h);
        vsync_i = vinv;
        if (vglitch) begin
          wait_cyc(a);
          vsync_i = ~vinv; wait_cyc(1);
          vsync_i = vinv;  wait_cyc(p - h - a - 1);
        end else wait_cyc(p - h);
      end
    end
  end

  initial begin : hgen
    @(posedge rst_ni);
    wait_cyc(1);
    forever begin
      if (cmode) begin
        hsync_i = 1'b1; wait_cyc(96);
        for (int l = 0; l < 10; l++) begin
          hsync_i = 1'b0; wait_cyc(28);
          hsync_i = 1'b1; wait_cyc(4);
        end
      end else if (hper == 0) wait_cyc(1);
      else begin
        int p, h;
        p = hper; h = hhi;
        hsync_i = ~hinv; wait_cyc(h);
        hsync_i = hinv;  wait_cyc(p - h);
      end
    end
  end

  // scoreboard for latched vertical results
  typedef struct {int exp; string req;} item_t;
  item_t sb_q[$];

  always @(negedge clk_i) begin
    if (rst_ni && vint_o && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      chk(it.req, int'(vcnt_o), it.exp);
    end
  end

  task automatic expect_v(int exp, int n, string req);
    do @(negedge clk_i); while (!vint_o);
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R3 vint width", int'(vint_o), 0);
    for (int i = 0; i < n; i++) sb_q.push_back('{exp, req});
    while (sb_q.size() > 0) @(negedge clk_i);
  endtask

  task automatic pulse_clr(bit vert);
    @(posedge clk_i); #1;
    if (vert) clr_vovf_i = 1'b1; else clr_hovf_i = 1'b1;
    @(posedge clk_i); #1;
    clr_vovf_i = 1'b0; clr_hovf_i = 1'b0;
    @(negedge clk_i);
  endtask

  bit done = 0;
  initial begin : watchdog
    int c;
    for (c = 0; c < 150000 && !done; c++) @(posedge clk_i);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", c, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk_i);
    chk("R1 vcnt", int'(vcnt_o), 0);
    chk("R1 hcnt", int'(hcnt_o), 0);
    chk("R1 flags", int'({vovf_o, hovf_o, vint_o, vpol_o, hpol_o}), 0);
    @(posedge clk_i); #1 rst_ni = 1'b1;

    hper = 32; hhi = 4; vper = 400; vhi = 20;
    wait_cyc(2000);
    chk("R6 vpol positive", int'(vpol_o), 1);
    chk("R6 hpol positive", int'(hpol_o), 1);
    chk("R5 hovf clear", int'(hovf_o), 0);
    expect_v(25, 3, "R2 period 400");
    chk("R4 hcnt 32-cycle lines", int'(hcnt_o), 8);

    vper = 640; wait_cyc(2000);
    expect_v(40, 2, "R2 period 640");

    hper = 16; wait_cyc(800);
    chk("R4 hcnt 16-cycle lines", int'(hcnt_o), 16);
    hper = 32;

    vper = 400; vinv = 1'b1; wait_cyc(2500);
    chk("R6 vpol negative", int'(vpol_o), 0);
    expect_v(25, 2, "R2 negative leading edge");

    hinv = 1'b1; wait_cyc(1000);
    chk("R6 hpol negative", int'(hpol_o), 0);
    chk("R4 hcnt negative", int'(hcnt_o), 8);
    hinv = 1'b0;

    vinv = 1'b0; vglitch = 1'b1; wait_cyc(2500);
    expect_v(25, 3, "R7 glitches ignored");
    chk("R7 vpol unaffected", int'(vpol_o), 1);
    vglitch = 1'b0;

    vper = 1200; wait_cyc(4000);
    expect_v(63, 2, "R5 vertical saturation");
    chk("R5 vovf set", int'(vovf_o), 1);
    vper = 400; wait_cyc(2500);
    expect_v(25, 1, "R2 after overflow");
    chk("R5 vovf sticky", int'(vovf_o), 1);
    pulse_clr(1'b1);
    chk("R5 vovf cleared", int'(vovf_o), 0);
    wait_cyc(1000);
    chk("R5 vovf stays clear", int'(vovf_o), 0);

    hper = 4; hhi = 2; wait_cyc(1000);
    chk("R5 hcnt saturated", int'(hcnt_o), 63);
    chk("R5 hovf set", int'(hovf_o), 1);
    hper = 32; hhi = 4; wait_cyc(1000);
    chk("R4 hcnt recovered", int'(hcnt_o), 8);
    chk("R5 hovf sticky", int'(hovf_o), 1);
    pulse_clr(1'b0);
    chk("R5 hovf cleared", int'(hovf_o), 0);

    cmode = 1'b1; comp_mode_i = 1'b1; wait_cyc(3000);
    expect_v(26, 2, "R8 composite frame");
    chk("R6 hpol ignores long period", int'(hpol_o), 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule